// File: doc/BRIEF.md
# Condition Register Field Move Unit

This block keeps a 32-bit condition register made of eight 4-bit fields. Field 0 is the most significant nibble and field 7 the least significant. On a strobed cycle the block copies one whole field into another field and leaves the other seven fields as they were. It can also replace the whole register from an external value.

Alongside the register, the block decodes which field the current operation writes. It takes a 2-bit operation code, a 3-bit destination operand and a record bit. From these it produces a write-field index, a valid flag and a one-hot field mask. The mask bits are ordered to match the nibble positions in the register. The datapath uses the same mask to pick the destination nibble. A write-port decoder that dropped the top bit of the destination operand would target the wrong field, so the decoder keeps all three bits.

Top module: `cr_field_move`

## Requirements
- R1: While `rst_ni` is low, and after it is released, until the first update, `cr_o` reads 0.
- R2: Field n is held in `cr_o[31-4n : 28-4n]`. Field 0 is therefore bits 31:28 and field 7 is bits 3:0.
- R3: With `valid_i`=1, `load_i`=0 and `op_i`=2'b01 (move), the next `cr_o` has field `dst_i` equal to the old field `src_i`, and the other fields are unchanged. Starting from 0xFEFF0001, moving field 0 into field 5 gives 0xFEFF0F01.
- R4: The destination uses all three bits of `dst_i`. A move into fields 4 to 7 writes exactly that field and never fields 0 to 3.
- R5: A move with `src_i` equal to `dst_i` leaves `cr_o` unchanged.
- R6: `cr_o` changes only on a rising edge where `valid_i`=1 and either `load_i`=1 or `op_i` is move. Op codes 2'b00, 2'b10 and 2'b11 never change `cr_o`.
- R7: With `valid_i`=1 and `load_i`=1, the next `cr_o` equals `load_data_i`, whatever `op_i` is.
- R8: With `op_i`=2'b01, `wr_idx_o`=`dst_i` and `wr_vld_o`=1.
- R9: With `op_i`=2'b10 (record form), `wr_idx_o`=0 and `wr_vld_o` equals `rc_i`.
- R10: With `op_i` equal to 2'b00 or 2'b11, `wr_vld_o`=0 and `wr_idx_o`=0.
- R11: `wr_mask_o` has only bit (7-`wr_idx_o`) set when `wr_vld_o`=1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 2 | 00 none, 01 move, 10 record form, 11 none |
| src_i | input | 3 | Source field index |
| dst_i | input | 3 | Destination field operand |
| rc_i | input | 1 | Record bit |
| load_i | input | 1 | Whole-register load request |
| load_data_i | input | 32 | Value for a whole-register load |
| cr_o | output | 32 | Condition register |
| wr_idx_o | output | 3 | Decoded write-field index |
| wr_vld_o | output | 1 | Write-field valid |
| wr_mask_o | output | 8 | One-hot written-field mask, bit 7 = field 0 |

## Verification
The bench builds the block with its default parameters: eight fields of four bits. At that size all 64 source and destination pairs can be covered by an exhaustive sweep from a register where every nibble is distinct. This exposes any swapped, mirrored or truncated field index. Random cycles then mix loads, moves, record-form decodes and idle strobes, so load-over-move priority and hold behaviour are exercised against the bench model.

// File: rtl/cr_move_pkg.sv
package cr_move_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_MOVE = 2'd1,
    OP_REC  = 2'd2,
    OP_RSVD = 2'd3
  } cr_op_e;
endpackage

// File: rtl/cr_wr_decode.sv
module cr_wr_decode
  import cr_move_pkg::*;
#(
  parameter int NFIELD = 8,
  localparam int IDX_W = $clog2(NFIELD)
) (
  input  cr_op_e             op_i,
  input  logic [IDX_W-1:0]   dst_i,
  input  logic               rc_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic               vld_o,
  output logic [NFIELD-1:0]  mask_o
);
  always_comb begin
    idx_o = '0;
    vld_o = 1'b0;
    case (op_i)
      OP_MOVE: begin
        idx_o = dst_i;  // full operand width, no truncation
        vld_o = 1'b1;
      end
      OP_REC: begin
        idx_o = '0;
        vld_o = rc_i;
      end
      default: ;
    endcase
  end

  // mask bit order follows nibble order: field 0 at the top
  for (genvar f = 0; f < NFIELD; f++) begin : g_mask
    assign mask_o[NFIELD-1-f] = vld_o && (idx_o == IDX_W'(f));
  end
endmodule

// File: rtl/cr_field_dp.sv
module cr_field_dp #(
  parameter int NFIELD = 8,
  parameter int FW     = 4,
  localparam int CR_W  = NFIELD * FW,
  localparam int IDX_W = $clog2(NFIELD)
) (
  input  logic [CR_W-1:0]   cr_i,
  input  logic [IDX_W-1:0]  src_i,
  input  logic [NFIELD-1:0] mask_i,
  output logic [CR_W-1:0]   cr_o
);
  logic [FW-1:0] fld [NFIELD];
  logic [FW-1:0] src_fld;

  for (genvar f = 0; f < NFIELD; f++) begin : g_fld
    assign fld[f] = cr_i[CR_W-1-FW*f -: FW];
    assign cr_o[CR_W-1-FW*f -: FW] = mask_i[NFIELD-1-f] ? src_fld : fld[f];
  end

  assign src_fld = fld[src_i];
endmodule

// File: rtl/cr_field_move.sv
module cr_field_move
  import cr_move_pkg::*;
#(
  parameter int NFIELD = 8,
  parameter int FW     = 4,
  localparam int CR_W  = NFIELD * FW,
  localparam int IDX_W = $clog2(NFIELD)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        op_i,
  input  logic [IDX_W-1:0]  src_i,
  input  logic [IDX_W-1:0]  dst_i,
  input  logic              rc_i,
  input  logic              load_i,
  input  logic [CR_W-1:0]   load_data_i,
  output logic [CR_W-1:0]   cr_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic              wr_vld_o,
  output logic [NFIELD-1:0] wr_mask_o
);
  cr_op_e          op;
  logic [CR_W-1:0] cr_q, cr_moved;

  assign op = cr_op_e'(op_i);

  cr_wr_decode #(.NFIELD(NFIELD)) i_dec (
    .op_i  (op),
    .dst_i (dst_i),
    .rc_i  (rc_i),
    .idx_o (wr_idx_o),
    .vld_o (wr_vld_o),
    .mask_o(wr_mask_o)
  );

  cr_field_dp #(.NFIELD(NFIELD), .FW(FW)) i_dp (
    .cr_i  (cr_q),
    .src_i (src_i),
    .mask_i(wr_mask_o),
    .cr_o  (cr_moved)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cr_q <= '0;
    end else if (valid_i) begin
      if (load_i)            cr_q <= load_data_i;
      else if (op == OP_MOVE) cr_q <= cr_moved;
    end
  end

  assign cr_o = cr_q;
endmodule

// File: rtl/cr_field_move_chk.sv
module cr_field_move_chk #(
  parameter int NFIELD = 8,
  parameter int FW     = 4,
  localparam int CR_W  = NFIELD * FW,
  localparam int IDX_W = $clog2(NFIELD)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [1:0]        op_i,
  input logic [IDX_W-1:0]  src_i,
  input logic [IDX_W-1:0]  dst_i,
  input logic              rc_i,
  input logic              load_i,
  input logic [CR_W-1:0]   load_data_i,
  input logic [CR_W-1:0]   cr_o,
  input logic [IDX_W-1:0]  wr_idx_o,
  input logic              wr_vld_o,
  input logic [NFIELD-1:0] wr_mask_o
);
  function automatic logic [FW-1:0] fld(logic [CR_W-1:0] v, logic [IDX_W-1:0] i);
    return v[CR_W-1-FW*int'(i) -: FW];
  endfunction

  function automatic logic [CR_W-1:0] expand(logic [NFIELD-1:0] m);
    logic [CR_W-1:0] r;
    for (int f = 0; f < NFIELD; f++) r[FW*f +: FW] = {FW{m[f]}};
    return r;
  endfunction

  logic mv;
  assign mv = valid_i && !load_i && (op_i == 2'b01);

  assert_move_copy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mv |=> fld(cr_o, $past(dst_i)) == fld($past(cr_o), $past(src_i)));

  assert_move_others_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mv |=> (cr_o & ~expand($past(wr_mask_o))) == ($past(cr_o) & ~expand($past(wr_mask_o))));

  assert_self_move_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mv && src_i == dst_i) |=> $stable(cr_o));

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && (load_i || op_i == 2'b01)) |=> $stable(cr_o));

  assert_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && load_i) |=> cr_o == $past(load_data_i));

  assert_move_dec_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b01) |-> (wr_vld_o && wr_idx_o == dst_i));

  assert_rec_dec_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b10) |-> (wr_idx_o == '0 && wr_vld_o == rc_i));

  assert_none_dec_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b00 || op_i == 2'b11) |-> (!wr_vld_o && wr_idx_o == '0));

  assert_mask_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_mask_o) && (wr_vld_o == ($countones(wr_mask_o) == 1))
    && (!wr_vld_o || wr_mask_o[NFIELD-1-int'(wr_idx_o)]));
endmodule

bind cr_field_move cr_field_move_chk #(.NFIELD(NFIELD), .FW(FW)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
  .src_i(src_i), .dst_i(dst_i), .rc_i(rc_i), .load_i(load_i),
  .load_data_i(load_data_i), .cr_o(cr_o), .wr_idx_o(wr_idx_o),
  .wr_vld_o(wr_vld_o), .wr_mask_o(wr_mask_o)
);

// File: tb/test_cr_field_move.sv
module test_cr_field_move;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic [2:0]  src_i = '0, dst_i = '0;
  logic        rc_i = 1'b0, load_i = 1'b0;
  logic [31:0] load_data_i = '0;
  logic [31:0] cr_o;
  logic [2:0]  wr_idx_o;
  logic        wr_vld_o;
  logic [7:0]  wr_mask_o;

  int total = 0, bad = 0;
  logic [31:0] model = '0;

  always #4 clk_i = ~clk_i;

  cr_field_move i_cr_field_move (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .src_i(src_i), .dst_i(dst_i), .rc_i(rc_i), .load_i(load_i),
    .load_data_i(load_data_i), .cr_o(cr_o), .wr_idx_o(wr_idx_o),
    .wr_vld_o(wr_vld_o), .wr_mask_o(wr_mask_o)
  );

  function automatic logic [3:0] get_f(logic [31:0] v, int i);
    return v[31-4*i -: 4];
  endfunction

  function automatic logic [31:0] put_f(logic [31:0] v, int i, logic [3:0] x);
    logic [31:0] r = v;
    r[31-4*i -: 4] = x;
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(bit v, logic [1:0] op, logic [2:0] s, logic [2:0] d,
                      bit rc, bit ld, logic [31:0] ldd, string req);
    logic [2:0]  e_idx;
    logic        e_vld;
    logic [7:0]  e_mask;
    logic [31:0] e_cr;
    @(negedge clk_i);
    valid_i = v; op_i = op; src_i = s; dst_i = d; rc_i = rc;
    load_i = ld; load_data_i = ldd;
    #1;
    case (op)
      2'b01:   begin e_idx = d; e_vld = 1'b1; end
      2'b10:   begin e_idx = '0; e_vld = rc; end
      default: begin e_idx = '0; e_vld = 1'b0; end
    endcase
    e_mask = e_vld ? (8'h80 >> e_idx) : 8'h00;
    chk(op == 2'b01 ? "R8" : (op == 2'b10 ? "R9" : "R10"), {28'd0, e_vld, e_idx},
        {28'd0, wr_vld_o, wr_idx_o});
    chk("R11", {24'd0, wr_mask_o}, {24'd0, e_mask});
    e_cr = model;
    if (v && ld) e_cr = ldd;
    else if (v && op == 2'b01) e_cr = put_f(model, int'(d), get_f(model, int'(s)));
    @(posedge clk_i); #1;
    chk(req, cr_o, e_cr);
    model = e_cr;
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk_i);
    chk("R1", cr_o, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", cr_o, 32'h0);

    step(1, 2'b00, 0, 0, 0, 1, 32'hFEFF0001, "R7");
    step(1, 2'b01, 0, 5, 0, 0, 32'h0, "R3");
    chk("R3", cr_o, 32'hFEFF0F01);

    step(1, 2'b00, 0, 0, 0, 1, 32'h12345678, "R7");
    step(1, 2'b01, 0, 4, 0, 0, 32'h0, "R4");
    chk("R4", cr_o, 32'h12341678);
    chk("R2", {28'd0, get_f(cr_o, 7)}, 32'h8);

    step(1, 2'b01, 6, 6, 0, 0, 32'h0, "R5");
    chk("R5", cr_o, 32'h12341678);
    step(0, 2'b01, 0, 7, 0, 0, 32'h0, "R6");
    step(1, 2'b10, 0, 3, 1, 0, 32'h0, "R9");
    step(1, 2'b10, 0, 3, 0, 0, 32'h0, "R9");
    step(1, 2'b11, 2, 3, 1, 0, 32'h0, "R10");
    step(1, 2'b01, 1, 2, 0, 1, 32'hCAFEF00D, "R7");
    chk("R7", cr_o, 32'hCAFEF00D);

    for (int s = 0; s < 8; s++)
      for (int d = 0; d < 8; d++) begin
        step(1, 2'b00, 0, 0, 0, 1, 32'h01234567, "R7");
        step(1, 2'b01, 3'(s), 3'(d), 0, 0, 32'h0, d >= 4 ? "R4" : "R3");
      end

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r = $urandom;
      step(r[0], r[2:1], r[5:3], r[8:6], r[9], r[12:10] == 0, $urandom,
           r[2:1] == 2'b01 ? "R3" : "R6");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule